// File: doc/BRIEF.md
# Firmware Record Stream Loader

This block turns a byte stream carrying a firmware image into byte writes on a memory write port. The image is a chain of records. Each record starts with a six-byte header, a 32-bit target address followed by a 16-bit payload length, both least significant byte first. The payload bytes follow the header and are written one by one to the target address, the next address, and so on.

The total image size is sampled when `start` is seen while the loader is idle. Before a header is accepted the loader checks that six bytes remain in the image. Before any payload byte is accepted it checks that the record's length fits in what remains. If either check fails, the load ends with an error and no byte of the offending header or record is taken. A load that consumes exactly the declared size ends cleanly. Completion is a one-cycle `done` pulse, and `error` is valid in the same cycle.

Top module: `fw_rec_loader`

## Requirements
- R1: While `rst_n` is low, and afterwards until a `start` is seen, `in_ready`, `wr_en` and `done` are all low.
- R2: A header is four address bytes followed by two length bytes, and the first byte of each field is its least significant byte.
- R3: Each payload byte causes exactly one write, in stream order, carrying that byte. The first byte goes to the header address and each later byte goes to the previous address plus one, wrapping modulo 2^32.
- R4: For each write, `wr_addr` is the byte address with bits [1:0] cleared, and `wr_lane` equals bits [1:0] of the byte address.
- R5: When the bytes consumed equal the image size at a header boundary, `done` pulses with `error` low and no further byte is accepted.
- R6: If a header is due and between one and five image bytes remain, `done` pulses with `error` high and none of those bytes is accepted.
- R7: If a record's length exceeds the image bytes left after its header, `done` pulses with `error` high, and no payload byte of that record is accepted or written.
- R8: A record of length zero produces no write, and the next header follows directly.
- R9: `done` is high for exactly one cycle per load. `in_ready` is low in that cycle and stays low until the next `start`. A `start` during a load has no effect on that load.
- R10: An image size of zero ends the load with `done` and `error` low, and no byte is accepted.
- R11: No byte is accepted and no write is issued in a cycle where `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a load (used only when idle) |
| image_len | input | 32 | Image size in bytes, sampled with `start` |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Loader takes the byte this cycle |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | 32 | Word-aligned write address |
| wr_lane | output | 2 | Byte lane within the word |
| wr_data | output | 8 | Byte to write |
| done | output | 1 | One-cycle end-of-load pulse |
| error | output | 1 | Load failed; valid with `done` |

## Verification
Four properties are checked on every cycle. Consecutive-cycle writes step the byte address by exactly one. `done` never lasts two cycles. The `done` cycle accepts no byte and writes nothing. A write is never directly followed by `done`. The parsing itself can only be shown by the bench scenarios. These cover the byte order of the header fields, the exact write sequence and wrap-around, and the byte counts at which an image is judged short or overlong. They also cover zero-length records, stalls on `in_valid`, and a `start` raised during a load.

// File: rtl/fwl_pkg.sv
// Shared definitions for the firmware record loader.
package fwl_pkg;

    // Loader control states.
    typedef enum logic [2:0] {
        LD_IDLE  = 3'd0,
        LD_HEAD  = 3'd1,
        LD_CHECK = 3'd2,
        LD_PAY   = 3'd3,
        LD_FIN   = 3'd4
    } ld_state_t;

endpackage

// File: rtl/fwl_hdr_asm.sv
// Header assembler.
// Collects HDR_BYTES stream bytes into one header register, least
// significant byte first. Address field is at the bottom, length above it.
// Assumes cap is raised only for header bytes. The index wraps by itself
// after the last header byte.
module fwl_hdr_asm #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap,
    input  logic [7:0]        byte_in,
    output logic              last_o,
    output logic [ADDR_W-1:0] dest_o,
    output logic [LEN_W-1:0]  len_o
);
    localparam int HDR_W     = ADDR_W + LEN_W;
    localparam int HDR_BYTES = HDR_W / 8;
    localparam int IDX_W     = $clog2(HDR_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_BYTES - 1);

    logic [IDX_W-1:0] idx;
    logic [HDR_W-1:0] hdr;

    // Byte index inside the header being gathered.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx <= '0;
        end else if (cap) begin
            idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
        end
    end

    // One capture register per header byte.
    for (genvar g = 0; g < HDR_BYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hdr[g*8 +: 8] <= 8'h00;
            end else if (cap && idx == IDX_W'(g)) begin
                hdr[g*8 +: 8] <= byte_in;
            end
        end
    end

    assign last_o = cap && (idx == LAST_IDX);
    assign dest_o = hdr[ADDR_W-1:0];
    assign len_o  = hdr[HDR_W-1:ADDR_W];
endmodule

// File: rtl/fwl_cursor.sv
// Position tracker.
// Holds the image bytes still unconsumed, the current write address and
// the payload bytes left in the current record.
// Assumes ld_img, ld_rec and step are mutually exclusive, and that ld_rec
// is used only when at least HDR_BYTES bytes remain.
module fwl_cursor #(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int SIZE_W    = 32,
    parameter int HDR_BYTES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_img,
    input  logic [SIZE_W-1:0] img_len,
    input  logic              ld_rec,
    input  logic [ADDR_W-1:0] rec_dest,
    input  logic [LEN_W-1:0]  rec_len,
    input  logic              step,
    output logic [SIZE_W-1:0] remain_o,
    output logic [ADDR_W-1:0] dest_o,
    output logic [LEN_W-1:0]  plen_o
);
    // Remaining-byte counter: load, charge header, charge payload byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_o <= '0;
        end else if (ld_img) begin
            remain_o <= img_len;
        end else if (ld_rec) begin
            remain_o <= remain_o - SIZE_W'(HDR_BYTES);
        end else if (step) begin
            remain_o <= remain_o - 1'b1;
        end
    end

    // Write address and record byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_o <= '0;
            plen_o <= '0;
        end else if (ld_rec) begin
            dest_o <= rec_dest;
            plen_o <= rec_len;
        end else if (step) begin
            dest_o <= dest_o + 1'b1;
            plen_o <= plen_o - 1'b1;
        end
    end
endmodule

// File: rtl/fwl_ctrl.sv
// Loader sequencer.
// Decides when stream bytes are taken as header or payload. Runs the size
// checks at each header boundary and produces the done/error outcome.
// Assumes the cursor and header assembler update on the strobes issued here.
module fwl_ctrl
    import fwl_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int SIZE_W    = 32,
    parameter int HDR_BYTES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_valid,
    input  logic              hdr_last,
    input  logic [LEN_W-1:0]  rec_len,
    input  logic [SIZE_W-1:0] remain,
    input  logic [LEN_W-1:0]  plen,
    output logic              in_ready,
    output logic              cap,
    output logic              step,
    output logic              ld_img,
    output logic              ld_rec,
    output logic              done,
    output logic              error
);
    localparam logic [SIZE_W-1:0] HDR_SZ = SIZE_W'(HDR_BYTES);

    ld_state_t st, st_nxt;
    logic      err_q, err_nxt;
    logic      hdr_room, rec_fits, accept;

    // Size checks against what is left of the image.
    assign hdr_room = (remain >= HDR_SZ);
    assign rec_fits = (SIZE_W'(rec_len) <= (remain - HDR_SZ));

    // Handshake and datapath strobes.
    assign in_ready = ((st == LD_HEAD) && hdr_room) || (st == LD_PAY);
    assign accept   = in_valid && in_ready;
    assign cap      = accept && (st == LD_HEAD);
    assign step     = accept && (st == LD_PAY);
    assign ld_img   = (st == LD_IDLE) && start;
    assign ld_rec   = (st == LD_CHECK);
    assign done     = (st == LD_FIN);
    assign error    = err_q;

    // Next-state and outcome decision.
    always_comb begin
        st_nxt  = st;
        err_nxt = err_q;
        case (st)
            LD_IDLE: begin
                if (start) begin
                    st_nxt  = LD_HEAD;
                    err_nxt = 1'b0;
                end
            end
            LD_HEAD: begin
                if (remain == '0) begin
                    st_nxt = LD_FIN;
                end else if (!hdr_room) begin
                    st_nxt  = LD_FIN;
                    err_nxt = 1'b1;
                end else if (hdr_last) begin
                    st_nxt = LD_CHECK;
                end
            end
            LD_CHECK: begin
                if (!rec_fits) begin
                    st_nxt  = LD_FIN;
                    err_nxt = 1'b1;
                end else if (rec_len == '0) begin
                    st_nxt = LD_HEAD;
                end else begin
                    st_nxt = LD_PAY;
                end
            end
            LD_PAY: begin
                if (step && plen == LEN_W'(1)) begin
                    st_nxt = LD_HEAD;
                end
            end
            LD_FIN:  st_nxt = LD_IDLE;
            default: st_nxt = LD_IDLE;
        endcase
    end

    // State and error flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= LD_IDLE;
            err_q <= 1'b0;
        end else begin
            st    <= st_nxt;
            err_q <= err_nxt;
        end
    end
endmodule

// File: rtl/fw_rec_loader.sv
// Firmware record stream loader, top level.
// Parses {address, length, payload} records from a byte stream and writes
// each payload byte to memory with a word address and byte lane. Each header
// and record is bounded by the image size sampled at start.
// Assumes the memory takes one byte write per cycle without back-pressure.
module fw_rec_loader #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int SIZE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SIZE_W-1:0] image_len,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [1:0]        wr_lane,
    output logic [7:0]        wr_data,
    output logic              done,
    output logic              error
);
    localparam int HDR_BYTES = (ADDR_W + LEN_W) / 8;
    localparam int LANE_W    = 2;

    logic              cap, step, ld_img, ld_rec, hdr_last;
    logic [ADDR_W-1:0] hdr_dest, cur_dest;
    logic [LEN_W-1:0]  hdr_len, cur_plen;
    logic [SIZE_W-1:0] remain;

    fwl_hdr_asm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_hdr (
        .clk(clk), .rst_n(rst_n), .clr(ld_img), .cap(cap), .byte_in(in_data),
        .last_o(hdr_last), .dest_o(hdr_dest), .len_o(hdr_len)
    );

    fwl_cursor #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W),
                 .HDR_BYTES(HDR_BYTES)) u_cur (
        .clk(clk), .rst_n(rst_n), .ld_img(ld_img), .img_len(image_len),
        .ld_rec(ld_rec), .rec_dest(hdr_dest), .rec_len(hdr_len), .step(step),
        .remain_o(remain), .dest_o(cur_dest), .plen_o(cur_plen)
    );

    fwl_ctrl #(.LEN_W(LEN_W), .SIZE_W(SIZE_W), .HDR_BYTES(HDR_BYTES)) u_ctl (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .hdr_last(hdr_last), .rec_len(hdr_len), .remain(remain), .plen(cur_plen),
        .in_ready(in_ready), .cap(cap), .step(step), .ld_img(ld_img),
        .ld_rec(ld_rec), .done(done), .error(error)
    );

    // Write port: aligned word address plus lane from the byte address.
    assign wr_en   = step;
    assign wr_addr = {cur_dest[ADDR_W-1:LANE_W], LANE_W'(0)};
    assign wr_lane = cur_dest[LANE_W-1:0];
    assign wr_data = in_data;
endmodule

// File: rtl/fwl_loader_chk.sv
// Property checker for the record loader, bound to the top level.
// Assumes a two-bit lane and one write per cycle at most.
module fwl_loader_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [1:0]        wr_lane,
    input logic              done
);
    logic [ADDR_W-1:0] byte_addr;
    assign byte_addr = wr_addr | ADDR_W'(wr_lane);

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (byte_addr == $past(byte_addr) + 1'b1));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!in_ready && !wr_en));

    // R5
    no_write_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !$past(wr_en));
endmodule

bind fw_rec_loader fwl_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_lane(wr_lane), .done(done)
);

// File: tb/fw_rec_loader_tb.sv
`timescale 1ns/100ps
module fw_rec_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] image_len = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready, wr_en, done, error;
    logic [31:0] wr_addr;
    logic [1:0]  wr_lane;
    logic [7:0]  wr_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    fw_rec_loader u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .image_len(image_len),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_lane(wr_lane), .wr_data(wr_data),
        .done(done), .error(error)
    );

    // Scenario table: {dest, rec_len, image_len, exp_consumed, exp_writes, exp_err}.
    // After the first payload, the stream carries zero bytes (zero-length headers).
    localparam int NV = 9;
    localparam logic [127:0] VEC [NV] = '{
        {32'h0000_1000, 16'd4, 32'd10, 16'd10, 16'd4, 16'd0},  // exact fit
        {32'h0000_2003, 16'd5, 32'd11, 16'd11, 16'd5, 16'd0},  // unaligned start
        {32'h1234_5678, 16'd3, 32'd15, 16'd15, 16'd3, 16'd0},  // trailing empty record
        {32'h0000_0010, 16'd8, 32'd10, 16'd6,  16'd0, 16'd1},  // record too long
        {32'h0000_0000, 16'd0, 32'd4,  16'd0,  16'd0, 16'd1},  // short header
        {32'h0000_0000, 16'd0, 32'd0,  16'd0,  16'd0, 16'd0},  // empty image
        {32'hFFFF_FFFE, 16'd4, 32'd10, 16'd10, 16'd4, 16'd0},  // address wrap
        {32'h0000_0100, 16'd2, 32'd11, 16'd8,  16'd2, 16'd1},  // short second header
        {32'h0000_0040, 16'd0, 32'd6,  16'd6,  16'd0, 16'd0}   // lone empty record
    };

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 7 + 3) & 8'hFF);
    endfunction

    function automatic logic [7:0] stream_byte(input logic [127:0] e, input int idx);
        logic [31:0] d;
        logic [15:0] l;
        d = e[127:96];
        l = e[95:80];
        if (idx < 4) return d[idx*8 +: 8];
        if (idx < 6) return l[(idx-4)*8 +: 8];
        if (idx < 6 + int'(l)) return pat(idx - 6);
        return 8'h00;
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    logic [31:0] got_addr [64];
    logic [7:0]  got_data [64];

    task automatic run_vec(input int i, input logic gaps, input logic poke);
        logic [127:0] e;
        int idx, nw;
        logic seen, err_seen, stall_bad, addr_ok;
        e = VEC[i];
        idx = 0; nw = 0; seen = 0; err_seen = 0; stall_bad = 0; addr_ok = 1;
        @(negedge clk);
        start = 1'b1;
        image_len = e[79:48];
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < 400; cyc++) begin
            if (cyc != 0) @(negedge clk);
            in_valid = gaps ? (cyc % 3 != 2) : 1'b1;
            in_data  = stream_byte(e, idx);
            if (poke) begin
                start = 1'b1;
                image_len = 32'd0;
            end
            #1;
            if (done) begin
                seen = 1; err_seen = error;
                start = 1'b0;
                break;
            end
            if (!in_valid && (wr_en || in_ready && 1'b0)) stall_bad = 1;
            if (in_valid && in_ready) begin
                if (wr_en && nw < 64) begin
                    got_addr[nw] = wr_addr | {30'd0, wr_lane};
                    got_data[nw] = wr_data;
                    if (wr_addr[1:0] != 2'b00) addr_ok = 0;
                    nw++;
                end
                idx++;
            end
        end
        start = 1'b0;
        in_valid = 1'b0;
        check(seen, "R5", $sformatf("vec %0d done seen", i), seen, 1);
        check(err_seen == e[0], "R6/R7/R10", $sformatf("vec %0d error", i),
              err_seen, e[0]);
        check(idx == int'(e[47:32]), "R5/R6/R7", $sformatf("vec %0d bytes consumed", i),
              idx, e[47:32]);
        check(nw == int'(e[31:16]), "R3/R8", $sformatf("vec %0d write count", i),
              nw, e[31:16]);
        for (int k = 0; k < nw && k < int'(e[31:16]); k++) begin
            if (got_addr[k] != e[127:96] + 32'(k)) begin
                addr_ok = 0;
                check(0, "R2/R3/R4", $sformatf("vec %0d write %0d address", i, k),
                      got_addr[k], e[127:96] + 32'(k));
            end
            if (got_data[k] != pat(k)) begin
                addr_ok = 0;
                check(0, "R3", $sformatf("vec %0d write %0d data", i, k),
                      got_data[k], pat(k));
            end
        end
        check(addr_ok, "R2/R3/R4", $sformatf("vec %0d write sequence", i), addr_ok, 1);
        if (gaps) check(!stall_bad, "R11", $sformatf("vec %0d write while stalled", i),
                        stall_bad, 0);
        @(negedge clk);
        #1;
        check(!done && !in_ready, "R9", $sformatf("vec %0d after done", i),
              {done, in_ready}, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: outputs quiet in reset
        repeat (3) @(negedge clk);
        #1;
        check(!in_ready && !wr_en && !done, "R1", "in reset",
              {in_ready, wr_en, done}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check(!in_ready && !wr_en && !done, "R1", "idle before start",
              {in_ready, wr_en, done}, 0);
        in_valid = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run_vec(i, i[0], (i == 1));
        end

        // R1: reset in mid-load returns to idle
        @(negedge clk);
        start = 1'b1;
        image_len = 32'd20;
        @(negedge clk);
        start = 1'b0;
        in_valid = 1'b1;
        in_data = 8'h11;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!in_ready && !wr_en && !done, "R1", "idle after mid-load reset",
              {in_ready, wr_en, done}, 0);
        in_valid = 1'b0;

        // R5/R8: a fresh load still works after that reset
        run_vec(8, 1'b0, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule